// File: doc/BRIEF.md
# Four-Port Core Memory Cycle Controller

This block stands in for one core memory module that four processor buses share. While it waits for work it looks at the cycle requests on all four ports and connects to one of them. Ports 0 and 1 win by fixed rank. Ports 2 and 3 rank below both and take turns with each other. On acceptance the controller captures the word address and the read and write flags of the chosen port, and it answers with an address acknowledge.

A core read destroys the word it reads. The controller mimics this: it clears the location as it reads it, then rewrites the buffered word on a read-only cycle. On a read-then-write cycle the buffer is emptied after the read. The controller then waits for the processor's write-restart pulse, merges the arriving word into the buffer by OR, and stores the result. A write-only cycle waits for the same pulse. While a cycle is open only the connected port can finish it; requests on the other ports stay pending.

Storage is an inferred synchronous RAM of 2^ADDR_W words of DATA_W bits. Every handshake output is a registered pulse one clock wide.

Top module: `cmem_ctrl`

## Requirements
- R1: While rst_n is low, and after it rises with no request pending, addr_ack, rd_rs and rd_data are all zero.
- R2: When several ports request at one accepting edge, port 0 wins over all others, port 1 wins over ports 2 and 3, and ports 2 and 3 are only granted when ports 0 and 1 are idle.
- R3: When ports 2 and 3 request together, the grant goes to the one of the two not granted last. The memory of the last grant is not cleared by reset and starts as "port 2", so the first such tie after power-on goes to port 3.
- R4: An accepted request on port p gives addr_ack == 1<<p for exactly one clock, one clock after the accepting edge.
- R5: On a cycle with the read flag set, rd_rs == 1<<p and rd_data holds the stored word for exactly one clock, one clock after addr_ack.
- R6: A read-only cycle leaves the location unchanged, so a later read of it returns the same word.
- R7: On a cycle with both flags set, the read returns the old word and the location then holds exactly the data present on the port's wr_data when its write-restart is sampled.
- R8: A write-only cycle stores the port's wr_data sampled with that port's write-restart pulse, and raises no rd_rs.
- R9: A write-restart pulse on a port that is not connected is ignored: it neither ends the open cycle nor changes any stored word.
- R10: No new cycle is accepted while one is open. addr_ack stays low from the acknowledge until the cycle ends, even with other ports requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cyc | input | 4 | Cycle request, one bit per port, held until acknowledged |
| req_rd | input | 4 | Read flag per port, valid with req_cyc |
| req_wr | input | 4 | Write flag per port, valid with req_cyc |
| req_addr | input | 4*ADDR_W | Word address per port; port p in bits [p*ADDR_W +: ADDR_W] |
| wr_rs | input | 4 | Write-restart pulse per port |
| wr_data | input | 4*DATA_W | Write word per port; port p in bits [p*DATA_W +: DATA_W] |
| addr_ack | output | 4 | Address acknowledge pulse, one-hot by port |
| rd_rs | output | 4 | Read-restart pulse, one-hot by port |
| rd_data | output | DATA_W | Read word, valid while rd_rs is high, zero otherwise |

## Verification
The acknowledge is due one clock after the accepting edge. The read strobe and its data are due one clock after that. A read-only cycle spends a further clock on the restore before the next request can be accepted at the following edge. A write ends on the edge that samples write-restart, and the next grant comes one edge later. The bench drives inputs and samples outputs on falling edges, and walks these edges with a reference model of grant order and memory contents. At each step it compares the whole acknowledge and strobe vectors, so that a pulse arriving a clock early, a clock late or on the wrong port is caught.

// File: rtl/cmem_pkg.sv
package cmem_pkg;
   localparam int NUM_PORTS = 4;
   localparam int PIDX_W    = $clog2(NUM_PORTS);

   typedef logic [PIDX_W-1:0] port_idx_t;

   typedef enum logic [1:0] {
      ST_AWAIT   = 2'd0,
      ST_READ    = 2'd1,
      ST_RESTORE = 2'd2,
      ST_WAIT_WR = 2'd3
   } cyc_state_e;
endpackage

// File: rtl/cmem_arbiter.sv
module cmem_arbiter
   import cmem_pkg::*;
(
   input  logic                 clk,
   input  logic                 accept_en,
   input  logic [NUM_PORTS-1:0] req,
   output logic                 gnt_vld,
   output port_idx_t            gnt_idx
);
   // Which of the shared pair went last; power-on value means port 2.
   // Deliberately outside reset.
   logic last_was_hi = 1'b0;

   always_comb begin
      gnt_vld = |req;
      if (req[0])
         gnt_idx = port_idx_t'(0);
      else if (req[1])
         gnt_idx = port_idx_t'(1);
      else if (req[2] && req[3])
         gnt_idx = last_was_hi ? port_idx_t'(2) : port_idx_t'(3);
      else if (req[2])
         gnt_idx = port_idx_t'(2);
      else
         gnt_idx = port_idx_t'(3);
   end

   always_ff @(posedge clk) begin
      if (accept_en && gnt_vld && gnt_idx[1])
         last_was_hi <= gnt_idx[0];
   end
endmodule

// File: rtl/cmem_array.sv
module cmem_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_q,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_d
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         store[wr_addr] <= wr_d;
      if (rd_en)
         rd_q <= store[rd_addr];
   end
endmodule

// File: rtl/cmem_seq.sv
module cmem_seq
   import cmem_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 36
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        gnt_vld,
   input  port_idx_t                   gnt_idx,
   input  logic [NUM_PORTS-1:0]        req_rd,
   input  logic [NUM_PORTS-1:0]        req_wr,
   input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
   input  logic [NUM_PORTS-1:0]        wr_rs,
   input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0]           arr_q,
   output logic                        accept_en,
   output logic                        arr_rd_en,
   output logic [ADDR_W-1:0]           arr_rd_addr,
   output logic                        arr_wr_en,
   output logic [ADDR_W-1:0]           arr_wr_addr,
   output logic [DATA_W-1:0]           arr_wr_d,
   output logic [NUM_PORTS-1:0]        addr_ack,
   output logic [NUM_PORTS-1:0]        rd_rs,
   output logic [DATA_W-1:0]           rd_data
);
   logic [ADDR_W-1:0] port_addr [NUM_PORTS];
   logic [DATA_W-1:0] port_wd   [NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slice
      assign port_addr[p] = req_addr[p*ADDR_W +: ADDR_W];
      assign port_wd[p]   = wr_data[p*DATA_W +: DATA_W];
   end

   cyc_state_e        state;
   port_idx_t         conn;
   logic [ADDR_W-1:0] cur_addr;
   logic              cur_rd;
   logic              cur_wr;
   logic [DATA_W-1:0] bufw;

   logic take;
   logic wr_done;

   assign accept_en = (state == ST_AWAIT);
   assign take      = accept_en && gnt_vld;
   assign wr_done   = (state == ST_WAIT_WR) && wr_rs[conn];

   always_comb begin
      arr_rd_en   = take;
      arr_rd_addr = port_addr[gnt_idx];
      arr_wr_addr = cur_addr;
      arr_wr_en   = 1'b0;
      arr_wr_d    = '0;
      unique case (state)
         ST_READ: begin
            arr_wr_en = 1'b1;
            arr_wr_d  = '0;
         end
         ST_RESTORE: begin
            arr_wr_en = 1'b1;
            arr_wr_d  = bufw;
         end
         ST_WAIT_WR: begin
            arr_wr_en = wr_rs[conn];
            arr_wr_d  = bufw | port_wd[conn];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_AWAIT;
         conn     <= '0;
         cur_addr <= '0;
         cur_rd   <= 1'b0;
         cur_wr   <= 1'b0;
         bufw     <= '0;
         addr_ack <= '0;
         rd_rs    <= '0;
         rd_data  <= '0;
      end else begin
         addr_ack <= '0;
         rd_rs    <= '0;
         rd_data  <= '0;
         unique case (state)
            ST_AWAIT: begin
               if (take) begin
                  conn     <= gnt_idx;
                  cur_addr <= port_addr[gnt_idx];
                  cur_rd   <= req_rd[gnt_idx];
                  cur_wr   <= req_wr[gnt_idx];
                  bufw     <= '0;
                  addr_ack <= NUM_PORTS'(1) << gnt_idx;
                  if (req_rd[gnt_idx])
                     state <= ST_READ;
                  else if (req_wr[gnt_idx])
                     state <= ST_WAIT_WR;
               end
            end
            ST_READ: begin
               rd_data <= arr_q;
               rd_rs   <= NUM_PORTS'(1) << conn;
               bufw    <= cur_wr ? '0 : arr_q;
               state   <= cur_wr ? ST_WAIT_WR : ST_RESTORE;
            end
            ST_RESTORE: begin
               state <= ST_AWAIT;
            end
            ST_WAIT_WR: begin
               if (wr_done) begin
                  bufw  <= bufw | port_wd[conn];
                  state <= ST_AWAIT;
               end
            end
            default: state <= ST_AWAIT;
         endcase
      end
   end

   logic unused_rd;
   assign unused_rd = cur_rd;
endmodule

// File: rtl/cmem_ctrl.sv
module cmem_ctrl
   import cmem_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 36
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        req_cyc,
   input  logic [NUM_PORTS-1:0]        req_rd,
   input  logic [NUM_PORTS-1:0]        req_wr,
   input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
   input  logic [NUM_PORTS-1:0]        wr_rs,
   input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
   output logic [NUM_PORTS-1:0]        addr_ack,
   output logic [NUM_PORTS-1:0]        rd_rs,
   output logic [DATA_W-1:0]           rd_data
);
   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 14)
         else $fatal(1, "cmem_ctrl: ADDR_W must lie in 1..14");
      assert (DATA_W >= 1 && DATA_W <= 64)
         else $fatal(1, "cmem_ctrl: DATA_W must lie in 1..64");
   end

   logic              accept_en;
   logic              gnt_vld;
   port_idx_t         gnt_idx;
   logic              arr_rd_en;
   logic [ADDR_W-1:0] arr_rd_addr;
   logic [DATA_W-1:0] arr_q;
   logic              arr_wr_en;
   logic [ADDR_W-1:0] arr_wr_addr;
   logic [DATA_W-1:0] arr_wr_d;

   cmem_arbiter u_arb (
      .clk       (clk),
      .accept_en (accept_en),
      .req       (req_cyc),
      .gnt_vld   (gnt_vld),
      .gnt_idx   (gnt_idx)
   );

   cmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .gnt_vld     (gnt_vld),
      .gnt_idx     (gnt_idx),
      .req_rd      (req_rd),
      .req_wr      (req_wr),
      .req_addr    (req_addr),
      .wr_rs       (wr_rs),
      .wr_data     (wr_data),
      .arr_q       (arr_q),
      .accept_en   (accept_en),
      .arr_rd_en   (arr_rd_en),
      .arr_rd_addr (arr_rd_addr),
      .arr_wr_en   (arr_wr_en),
      .arr_wr_addr (arr_wr_addr),
      .arr_wr_d    (arr_wr_d),
      .addr_ack    (addr_ack),
      .rd_rs       (rd_rs),
      .rd_data     (rd_data)
   );

   cmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk     (clk),
      .rd_en   (arr_rd_en),
      .rd_addr (arr_rd_addr),
      .rd_q    (arr_q),
      .wr_en   (arr_wr_en),
      .wr_addr (arr_wr_addr),
      .wr_d    (arr_wr_d)
   );
endmodule

// File: rtl/cmem_ctrl_chk.sv
module cmem_ctrl_chk
   import cmem_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_PORTS-1:0] req_cyc,
   input logic [NUM_PORTS-1:0] addr_ack,
   input logic [NUM_PORTS-1:0] rd_rs
);
   p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(addr_ack));

   p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|addr_ack) |=> (addr_ack == '0));

   p_ack_had_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|addr_ack) |-> ((addr_ack & ~$past(req_cyc)) == '0));

   p_port1_below0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ack[1] |-> !$past(req_cyc[0]));

   p_pair_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_ack[2] || addr_ack[3]) |-> ($past(req_cyc[1:0]) == 2'b00));

   p_rs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_rs));

   p_rs_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_rs) |-> (rd_rs == $past(addr_ack)));

   p_no_ack_with_rs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_rs) |-> (addr_ack == '0));
endmodule

bind cmem_ctrl cmem_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_cyc  (req_cyc),
   .addr_ack (addr_ack),
   .rd_rs    (rd_rs)
);

// File: tb/cmem_ctrl_tb.sv
`timescale 1ns/1ps
module cmem_ctrl_tb;
   localparam int AW = 10;
   localparam int DW = 36;
   localparam int NP = 4;
   localparam int POOL = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    req_cyc = '0;
   logic [NP-1:0]    req_rd = '0;
   logic [NP-1:0]    req_wr = '0;
   logic [NP*AW-1:0] req_addr = '0;
   logic [NP-1:0]    wr_rs = '0;
   logic [NP*DW-1:0] wr_data = '0;
   logic [NP-1:0]    addr_ack;
   logic [NP-1:0]    rd_rs;
   logic [DW-1:0]    rd_data;

   always #2.5 clk = ~clk;

   cmem_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_cyc(req_cyc), .req_rd(req_rd),
      .req_wr(req_wr), .req_addr(req_addr), .wr_rs(wr_rs),
      .wr_data(wr_data), .addr_ack(addr_ack), .rd_rs(rd_rs),
      .rd_data(rd_data)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [DW-1:0] mdl [POOL];
   bit            last_hi = 1'b0;
   logic [1:0]    r_op  [NP];
   int            r_idx [NP];
   logic [DW-1:0] r_dat [NP];

   function automatic logic [AW-1:0] pool_addr(int k);
      return (k < 8) ? AW'(k) : AW'((1 << AW) - POOL + k);
   endfunction

   function automatic int pick(logic [NP-1:0] rq, bit hi);
      if (rq[0]) return 0;
      if (rq[1]) return 1;
      if (rq[2] && rq[3]) return hi ? 2 : 3;
      if (rq[2]) return 2;
      return 3;
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // Serve every port in mask. r_op bit0 = read flag, bit1 = write flag.
   task automatic serve(logic [NP-1:0] mask);
      logic [NP-1:0] pend = mask;
      for (int p = 0; p < NP; p++) begin
         if (mask[p]) begin
            req_rd[p] = r_op[p][0];
            req_wr[p] = r_op[p][1];
            req_addr[p*AW +: AW] = pool_addr(r_idx[p]);
            req_cyc[p] = 1'b1;
         end
      end
      while (pend != '0) begin
         int w;
         w = pick(pend, last_hi);
         @(posedge clk); @(negedge clk);
         check(addr_ack == NP'(1 << w), "R2 R3 R4 grant", 64'(addr_ack), 64'(1 << w));
         if (w >= 2) last_hi = (w == 3);
         pend[w] = 1'b0;
         req_cyc[w] = 1'b0;
         if (r_op[w][0]) begin
            @(posedge clk); @(negedge clk);
            check(rd_rs == NP'(1 << w) && addr_ack == '0, "R5 R10 strobe",
                  64'({addr_ack, rd_rs}), 64'(1 << w));
            check(rd_data == mdl[r_idx[w]], "R5 R6 R7 data",
                  64'(rd_data), 64'(mdl[r_idx[w]]));
            if (!r_op[w][1]) begin
               @(posedge clk); @(negedge clk);
               check(addr_ack == '0 && rd_rs == '0, "R6 R10 restore",
                     64'({addr_ack, rd_rs}), 64'(0));
            end
         end
         if (r_op[w][1]) begin
            int gap = int'($urandom_range(0, 3));
            for (int g = 0; g < gap; g++) begin
               int o = (w + 1 + g) % NP;
               if (g == 0) begin
                  wr_rs[o] = 1'b1;
                  wr_data[o*DW +: DW] = ~r_dat[w];
               end
               @(posedge clk); @(negedge clk);
               wr_rs = '0;
               check(addr_ack == '0 && rd_rs == '0, "R9 R10 busy",
                     64'({addr_ack, rd_rs}), 64'(0));
            end
            wr_rs[w] = 1'b1;
            wr_data[w*DW +: DW] = r_dat[w];
            @(posedge clk); @(negedge clk);
            wr_rs = '0;
            check(rd_rs == '0, "R8 no strobe", 64'(rd_rs), 64'(0));
            mdl[r_idx[w]] = r_dat[w];
         end
      end
   endtask

   task automatic set_op(int p, logic [1:0] op, int idx);
      r_op[p]  = op;
      r_idx[p] = idx;
      r_dat[p] = DW'({$urandom(), $urandom()});
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int p = 0; p < NP; p++) set_op(p, 2'b00, 0);
      repeat (3) @(negedge clk);
      check(addr_ack == '0 && rd_rs == '0 && rd_data == '0, "R1 in reset",
            64'({addr_ack, rd_rs}), 64'(0));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(addr_ack == '0 && rd_rs == '0 && rd_data == '0, "R1 idle",
            64'({addr_ack, rd_rs}), 64'(0));

      // R8: fill the address pool by write-only cycles on ports 0 and 1.
      for (int k = 0; k < POOL; k++) begin
         set_op(k % 2, 2'b10, k);
         serve(NP'(1 << (k % 2)));
      end
      // R6: read twice, the restore must keep the word.
      set_op(1, 2'b01, 5); serve(4'b0010);
      set_op(1, 2'b01, 5); serve(4'b0010);
      // R3: first tie of the shared pair after power-on goes to port 3.
      set_op(2, 2'b01, 1); set_op(3, 2'b01, 2);
      serve(4'b1100);
      set_op(2, 2'b01, 3); set_op(3, 2'b01, 4);
      serve(4'b1100);
      // R2 R7: all four at once, mixed operations.
      set_op(0, 2'b11, 6); set_op(1, 2'b01, 6);
      set_op(2, 2'b11, 9); set_op(3, 2'b10, 15);
      serve(4'b1111);

      for (int n = 0; n < 400; n++) begin
         logic [NP-1:0] m;
         m = NP'($urandom_range(1, 15));
         for (int p = 0; p < NP; p++)
            set_op(p, 2'($urandom_range(1, 3)), int'($urandom_range(0, POOL-1)));
         serve(m);
      end
      // Final read-back of the whole pool.
      for (int k = 0; k < POOL; k++) begin
         set_op(k % NP, 2'b01, k);
         serve(NP'(1 << (k % NP)));
      end
      done = 1'b1;
      report();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         report();
      end
   end
endmodule